// File: doc/BRIEF.md
# USB Link Power State Manager

This block decides how much of one 5 Gbps USB redriver channel pair is powered. It never decodes link commands. It reads only the electrical evidence that its analog neighbours report as digital signals: the results of far-end receiver termination detection, the squelch (electrical idle) status and LFPS detection. From these it picks one of three working states.

- **Rx-detect**: no partner is present.
- **Power-saving (U2/U3)**: a partner is present but the link is idle.
- **Active**: the link is carrying traffic.

The block drives enables for the receive and transmit paths, the squelch detector, receive termination, common-mode hold and termination-detect polling. Whenever USB operation is switched off, everything is held off in deep power saving.

A polling timer paces the far-end termination checks in Rx-detect and power-saving. On each expiry it sends a one-cycle request to the detector, then waits for that detector's result strobe. A run of uninterrupted electrical idle while Active moves the link into power-saving. LFPS brings it back. A failed detection while in power-saving means the partner has gone, and the block returns to Rx-detect.

Top module: `lnkpwr_mgr`

## Requirements
- R1: While `usb_en` is low at a rising edge, the state after that edge is deep power saving: `link_state` = 0, all six enables low and `det_req` low. Reset gives the same state.
- R2: In deep power saving with `usb_en` high, the next edge moves the block to Rx-detect (`link_state` = 1).
- R3: The enables, as {rx_path_en, tx_path_en, squelch_en, rterm_en, cm_hold_en, poll_en}, follow the state:
  - deep power saving (0): 000000
  - Rx-detect (1): 000001
  - power-saving (2): 001111
  - Active (3): 111110
- R4: In Rx-detect and power-saving, `det_req` is a one-cycle pulse. It is high POLL_CYC edges after the state is entered, and POLL_CYC edges after each accepted result. No further request is issued while a result is outstanding, and none is issued outside those two states.
- R5: A `det_done` strobe is accepted only while a request is outstanding. At any other time it changes neither the state nor the polling timing.
- R6: In Rx-detect, an accepted result with `det_found` = 1 moves the block to Active. With `det_found` = 0 the block stays in Rx-detect.
- R7: In Active, the IDLE_CYC-th consecutive edge at which `sq_idle` is high moves the block to power-saving (`link_state` = 2). An edge with `sq_idle` low restarts the count.
- R8: In power-saving, `lfps_det` high at an edge moves the block to Active. This takes priority over a result accepted at the same edge. `lfps_det` has no effect in Rx-detect.
- R9: In power-saving, an accepted result with `det_found` = 0 moves the block to Rx-detect. With `det_found` = 1 the block stays in power-saving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_en | input | 1 | USB operation enabled; low selects deep power saving |
| sq_idle | input | 1 | Squelch reports electrical idle |
| lfps_det | input | 1 | LFPS detected |
| det_done | input | 1 | Termination-detect result valid strobe |
| det_found | input | 1 | Far-end termination present (valid with det_done) |
| det_req | output | 1 | One-cycle termination-detect request |
| rx_path_en | output | 1 | Receive path enable |
| tx_path_en | output | 1 | Transmit path enable |
| squelch_en | output | 1 | Squelch detector enable |
| rterm_en | output | 1 | Receive termination enable |
| cm_hold_en | output | 1 | Common-mode voltage hold enable |
| poll_en | output | 1 | Termination-detect polling enable |
| link_state | output | 2 | 0 deep power saving, 1 Rx-detect, 2 power-saving, 3 Active |

## Verification
State changes and enables are due one edge after the input that causes them. The enables decode the state register directly, so they add no further delay. `det_req` rises on the POLL_CYC-th edge after entry into a polling state or after an accepted result. The move to power-saving happens on the edge that samples the IDLE_CYC-th consecutive idle cycle.

The bench changes its inputs only on falling edges and reads outputs on the following falling edge. It counts edges explicitly for the polling and idle windows. A cycle-level reference model, built from the requirements, is compared on every cycle of both the directed and the random stimulus.

// File: rtl/lnkpwr_pkg.sv
package lnkpwr_pkg;

    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_RXDET  = 2'd1,
        PS_U23    = 2'd2,
        PS_ACTIVE = 2'd3
    } pwr_st_e;

    typedef struct packed {
        logic rx;
        logic tx;
        logic sq;
        logic rterm;
        logic cm;
        logic poll;
    } pwr_en_t;

    function automatic pwr_en_t en_of(pwr_st_e s);
        pwr_en_t e;
        e = '0;
        case (s)
            PS_RXDET:  e.poll = 1'b1;
            PS_U23:    begin e.sq = 1'b1; e.rterm = 1'b1; e.cm = 1'b1; e.poll = 1'b1; end
            PS_ACTIVE: begin e.rx = 1'b1; e.tx = 1'b1; e.sq = 1'b1; e.rterm = 1'b1; e.cm = 1'b1; end
            default:   e = '0;
        endcase
        return e;
    endfunction

    function automatic logic is_polling(pwr_st_e s);
        return (s == PS_RXDET) || (s == PS_U23);
    endfunction

endpackage

// File: rtl/lnkpwr_poll_timer.sv
module lnkpwr_poll_timer #(
    parameter int POLL_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic cur_poll,
    input  logic nxt_poll,
    input  logic det_done,
    output logic det_req,
    output logic res_ok
);
    localparam int PCW = (POLL_CYC > 2) ? $clog2(POLL_CYC) : 1;
    localparam logic [PCW-1:0] P_LAST = PCW'(POLL_CYC - 1);

    logic [PCW-1:0] cnt;
    logic           pending;

    assign res_ok = pending && det_done && cur_poll;

    always_ff @(posedge clk) begin
        if (rst || !cur_poll || !nxt_poll) begin
            cnt     <= '0;
            pending <= 1'b0;
            det_req <= 1'b0;
        end else begin
            det_req <= 1'b0;
            if (pending) begin
                if (det_done) pending <= 1'b0;
            end else if (cnt == P_LAST) begin
                cnt     <= '0;
                pending <= 1'b1;
                det_req <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lnkpwr_idle_filter.sv
module lnkpwr_idle_filter #(
    parameter int IDLE_CYC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic sq_idle,
    output logic idle_hit
);
    localparam int ICW = (IDLE_CYC > 2) ? $clog2(IDLE_CYC) : 1;
    localparam logic [ICW-1:0] I_LAST = ICW'(IDLE_CYC - 1);

    logic [ICW-1:0] run_len;

    assign idle_hit = armed && sq_idle && (run_len == I_LAST);

    always_ff @(posedge clk) begin
        if (rst || !armed || !sq_idle) begin
            run_len <= '0;
        end else if (run_len != I_LAST) begin
            run_len <= run_len + 1'b1;
        end
    end
endmodule

// File: rtl/lnkpwr_fsm.sv
module lnkpwr_fsm
    import lnkpwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    usb_en,
    input  logic    lfps_det,
    input  logic    det_found,
    input  logic    res_ok,
    input  logic    idle_hit,
    output pwr_st_e st,
    output pwr_st_e st_nxt
);
    always_comb begin
        st_nxt = st;
        if (!usb_en) begin
            st_nxt = PS_OFF;
        end else begin
            case (st)
                PS_OFF:    st_nxt = PS_RXDET;
                PS_RXDET:  if (res_ok && det_found) st_nxt = PS_ACTIVE;
                PS_ACTIVE: if (idle_hit) st_nxt = PS_U23;
                PS_U23: begin
                    if (lfps_det)                    st_nxt = PS_ACTIVE;
                    else if (res_ok && !det_found)   st_nxt = PS_RXDET;
                end
                default:   st_nxt = PS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= PS_OFF;
        else     st <= st_nxt;
    end
endmodule

// File: rtl/lnkpwr_mgr.sv
module lnkpwr_mgr
    import lnkpwr_pkg::*;
#(
    parameter int POLL_CYC = 64,
    parameter int IDLE_CYC = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       usb_en,
    input  logic       sq_idle,
    input  logic       lfps_det,
    input  logic       det_done,
    input  logic       det_found,
    output logic       det_req,
    output logic       rx_path_en,
    output logic       tx_path_en,
    output logic       squelch_en,
    output logic       rterm_en,
    output logic       cm_hold_en,
    output logic       poll_en,
    output logic [1:0] link_state
);
    pwr_st_e st;
    pwr_st_e st_nxt;
    logic    res_ok;
    logic    idle_hit;
    logic    cur_poll;
    logic    nxt_poll;
    logic    in_active;
    pwr_en_t en;

    assign cur_poll  = is_polling(st);
    assign nxt_poll  = is_polling(st_nxt);
    assign in_active = (st == PS_ACTIVE);

    lnkpwr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .usb_en    (usb_en),
        .lfps_det  (lfps_det),
        .det_found (det_found),
        .res_ok    (res_ok),
        .idle_hit  (idle_hit),
        .st        (st),
        .st_nxt    (st_nxt)
    );

    lnkpwr_poll_timer #(.POLL_CYC(POLL_CYC)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .cur_poll (cur_poll),
        .nxt_poll (nxt_poll),
        .det_done (det_done),
        .det_req  (det_req),
        .res_ok   (res_ok)
    );

    lnkpwr_idle_filter #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .armed    (in_active),
        .sq_idle  (sq_idle),
        .idle_hit (idle_hit)
    );

    assign en         = en_of(st);
    assign rx_path_en = en.rx;
    assign tx_path_en = en.tx;
    assign squelch_en = en.sq;
    assign rterm_en   = en.rterm;
    assign cm_hold_en = en.cm;
    assign poll_en    = en.poll;
    assign link_state = st;
endmodule

// File: rtl/lnkpwr_mgr_chk.sv
module lnkpwr_mgr_chk (
    input logic       clk,
    input logic       rst,
    input logic       usb_en,
    input logic       lfps_det,
    input logic       det_req,
    input logic       rx_path_en,
    input logic       tx_path_en,
    input logic       squelch_en,
    input logic       rterm_en,
    input logic       cm_hold_en,
    input logic       poll_en,
    input logic [1:0] link_state
);
    logic [5:0] ens;
    assign ens = {rx_path_en, tx_path_en, squelch_en, rterm_en, cm_hold_en, poll_en};

    p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (rst)
        !usb_en |=> (link_state == 2'd0 && ens == 6'b0 && !det_req));

    p_wake_to_rxdet_r2: assert property (@(posedge clk) disable iff (rst)
        (link_state == 2'd0 && usb_en) |=> link_state == 2'd1);

    p_rxdet_enables_r3: assert property (@(posedge clk) disable iff (rst)
        link_state == 2'd1 |-> ens == 6'b000001);

    p_u23_enables_r3: assert property (@(posedge clk) disable iff (rst)
        link_state == 2'd2 |-> ens == 6'b001111);

    p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
        det_req |=> !det_req);

    p_req_needs_polling_r4: assert property (@(posedge clk) disable iff (rst)
        det_req |-> poll_en);

    p_lfps_wake_r8: assert property (@(posedge clk) disable iff (rst)
        (link_state == 2'd2 && lfps_det && usb_en) |=> link_state == 2'd3);
endmodule

bind lnkpwr_mgr lnkpwr_mgr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .usb_en     (usb_en),
    .lfps_det   (lfps_det),
    .det_req    (det_req),
    .rx_path_en (rx_path_en),
    .tx_path_en (tx_path_en),
    .squelch_en (squelch_en),
    .rterm_en   (rterm_en),
    .cm_hold_en (cm_hold_en),
    .poll_en    (poll_en),
    .link_state (link_state)
);

// File: tb/lnkpwr_mgr_test.sv
module lnkpwr_mgr_test;
    localparam int P = 16;
    localparam int I = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic usb_en = 1'b0, sq_idle = 1'b0, lfps_det = 1'b0, det_done = 1'b0, det_found = 1'b0;
    logic det_req, rx_path_en, tx_path_en, squelch_en, rterm_en, cm_hold_en, poll_en;
    logic [1:0] link_state;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lnkpwr_mgr #(.POLL_CYC(P), .IDLE_CYC(I)) uut (
        .clk(clk), .rst(rst), .usb_en(usb_en), .sq_idle(sq_idle), .lfps_det(lfps_det),
        .det_done(det_done), .det_found(det_found), .det_req(det_req),
        .rx_path_en(rx_path_en), .tx_path_en(tx_path_en), .squelch_en(squelch_en),
        .rterm_en(rterm_en), .cm_hold_en(cm_hold_en), .poll_en(poll_en),
        .link_state(link_state)
    );

    function automatic logic [5:0] exp_en(logic [1:0] s);
        case (s)
            2'd1:    return 6'b000001;
            2'd2:    return 6'b001111;
            2'd3:    return 6'b111110;
            default: return 6'b000000;
        endcase
    endfunction

    function automatic bit polls(logic [1:0] s);
        return (s == 2'd1) || (s == 2'd2);
    endfunction

    // reference model built from the requirements
    logic [1:0] m_st = 2'd0;
    int  m_pc = 0, m_ic = 0;
    bit  m_wait = 0, m_req = 0;

    always @(posedge clk) begin
        logic [1:0] nx;
        bit acc, hit;
        if (rst) begin
            m_st = 2'd0; m_pc = 0; m_ic = 0; m_wait = 0; m_req = 0;
        end else begin
            acc = m_wait && det_done;
            hit = (m_st == 2'd3) && sq_idle && (m_ic == I - 1);
            nx  = m_st;
            if (!usb_en) nx = 2'd0;
            else case (m_st)
                2'd0: nx = 2'd1;
                2'd1: if (acc && det_found) nx = 2'd3;
                2'd3: if (hit) nx = 2'd2;
                default: if (lfps_det) nx = 2'd3; else if (acc && !det_found) nx = 2'd1;
            endcase
            if (!polls(m_st) || !polls(nx)) begin
                m_pc = 0; m_wait = 0; m_req = 0;
            end else begin
                m_req = 0;
                if (m_wait) begin
                    if (det_done) m_wait = 0;
                end else if (m_pc == P - 1) begin
                    m_pc = 0; m_wait = 1; m_req = 1;
                end else m_pc++;
            end
            if (m_st != 2'd3 || !sq_idle) m_ic = 0;
            else if (m_ic != I - 1) m_ic++;
            m_st = nx;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (!rst) begin
            chk("R3 model state", {6'b0, link_state}, {6'b0, m_st});
            chk("R3 model enables", {2'b0, rx_path_en, tx_path_en, squelch_en, rterm_en, cm_hold_en, poll_en},
                {2'b0, exp_en(m_st)});
            chk("R4 model det_req", {7'b0, det_req}, {7'b0, m_req});
        end
    endtask

    task automatic wait_req(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!det_req && n < 4 * P);
    endtask

    task automatic pulse_done(logic f, logic l);
        det_done = 1'b1; det_found = f; lfps_det = l;
        tick();
        det_done = 1'b0; lfps_det = 1'b0;
    endtask

    function automatic logic [7:0] ens();
        return {2'b0, rx_path_en, tx_path_en, squelch_en, rterm_en, cm_hold_en, poll_en};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R4: watchdog expired act=hung exp=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 reset state", {6'b0, link_state}, 8'd0);
        chk("R1 reset enables", ens(), 8'd0);

        usb_en = 1'b1;
        tick();
        chk("R2 enter rxdet", {6'b0, link_state}, 8'd1);
        chk("R3 rxdet enables", ens(), 8'h01);
        wait_req(n);
        chk("R4 first poll delay", n[7:0], 8'(P));
        tick();
        chk("R4 single pulse", {7'b0, det_req}, 8'd0);
        pulse_done(1'b0, 1'b0);
        chk("R6 not found stays", {6'b0, link_state}, 8'd1);
        pulse_done(1'b1, 1'b0);
        chk("R5 stray result ignored", {6'b0, link_state}, 8'd1);
        wait_req(n);
        chk("R5 timing unaffected", n[7:0], 8'(P - 1));
        lfps_det = 1'b1; tick(); lfps_det = 1'b0;
        chk("R8 lfps ignored in rxdet", {6'b0, link_state}, 8'd1);
        pulse_done(1'b1, 1'b0);
        chk("R6 found to active", {6'b0, link_state}, 8'd3);
        chk("R3 active enables", ens(), 8'h3E);

        sq_idle = 1'b1; repeat (I - 1) tick();
        sq_idle = 1'b0; tick();
        sq_idle = 1'b1; repeat (I - 1) tick();
        chk("R7 broken idle restarts", {6'b0, link_state}, 8'd3);
        tick();
        chk("R7 idle to u23", {6'b0, link_state}, 8'd2);
        chk("R3 u23 enables", ens(), 8'h0F);

        wait_req(n);
        chk("R4 u23 poll delay", n[7:0], 8'(P));
        pulse_done(1'b1, 1'b0);
        chk("R9 found stays u23", {6'b0, link_state}, 8'd2);
        wait_req(n);
        pulse_done(1'b0, 1'b1);
        chk("R8 lfps beats result", {6'b0, link_state}, 8'd3);
        repeat (I) tick();
        chk("R7 idle again", {6'b0, link_state}, 8'd2);
        lfps_det = 1'b1; tick(); lfps_det = 1'b0;
        chk("R8 lfps wake", {6'b0, link_state}, 8'd3);
        repeat (I) tick();
        wait_req(n);
        pulse_done(1'b0, 1'b0);
        chk("R9 lost partner", {6'b0, link_state}, 8'd1);

        usb_en = 1'b0; tick();
        chk("R1 disable state", {6'b0, link_state}, 8'd0);
        chk("R1 disable enables", {ens()[7:1], det_req}, 8'd0);
        repeat (3 * P) tick();
        chk("R1 no requests while off", {7'b0, det_req}, 8'd0);
        usb_en = 1'b1; tick();
        chk("R2 re-enter rxdet", {6'b0, link_state}, 8'd1);

        for (int k = 0; k < 20000; k++) begin
            usb_en    = ($urandom % 400) != 0;
            sq_idle   = ($urandom % 10) != 0;
            lfps_det  = ($urandom % 40) == 0;
            det_done  = ($urandom % 6) == 0;
            det_found = $urandom % 2;
            tick();
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule